// File: doc/BRIEF.md
# Pixel Interface Conditioning Stage

This stage sits in the pixel clock domain between a video timing generator and the pixel input of a serial display host. Each clock it takes three colour components together with a data-enable and two sync strobes. It returns them one clock later in a form the host expects: every strobe active high, each component routed to the output slot chosen by configuration, and any unused low-order bits cleared. For 4:2:2 luma/chroma output formats it also halves the chroma rate. It can keep the even pixel's chroma, keep the odd pixel's chroma, or average the two.

The pixel stream cannot stall. A video timing source cannot hold off a pixel, so there is no valid/ready handshake. A sample is accepted on every clock, and the data-enable strobe marks which samples are active pixels. All configuration inputs are static. They are changed only while the data-enable strobe is idle.

Components are MSB-aligned in `CW`-bit lanes (default 10). Slot 0 carries Y or R, slot 1 carries Cb or G, and slot 2 carries Cr or B.

Top module: `pix_cond_top`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: Each output slot takes the input component named by its 2-bit select: 0 picks component 0, 1 picks component 1 and 2 picks component 2. The selects 0/1/2 on slots 0/1/2 give a straight pass-through.
- R3: A select value of 3 picks component 0.
- R4: Each of DE, HSYNC and VSYNC has its own invert input. When that input is 1, the output is the complement of the input strobe; when it is 0, the output equals the input strobe.
- R5: All outputs are registered once. Every output value reflects the inputs of the preceding clock, so the strobes stay aligned with the data.
- R6: The input width code applies a mask to each input component before routing, keeping only its top bits and zeroing the rest. Code 0 keeps 10 bits. Code 1 keeps 8 bits. Code 2 keeps 6 bits. Code 3 keeps 5 bits on components 0 and 2 and 6 bits on component 1. Codes 4 to 7 keep all bits.
- R7: Output format codes 6, 7 and 8 are the 4:2:2 formats. Every other code, including 5 (24-bit RGB) and 4 (18-bit RGB), passes slots 1 and 2 through unchanged.
- R8: In a 4:2:2 format, active pixels form even/odd pairs, and pairing restarts on the first active pixel after DE was idle. Slots 1 and 2 output 0 on the even pixel of each pair and on every idle cycle. On the odd pixel they carry that pair's decimated Cb and Cr. Slot 0 always carries luma.
- R9: Chroma mode 0 outputs the even pixel's chroma. Mode 1 outputs the odd pixel's chroma. Mode 2 outputs (even + odd) >> 1, dropping any remainder. Mode 3 behaves as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_c0 | input | CW | Input component 0 |
| in_c1 | input | CW | Input component 1 |
| in_c2 | input | CW | Input component 2 |
| in_de | input | 1 | Data-enable strobe, polarity per cfg_inv_de |
| in_hs | input | 1 | Horizontal sync, polarity per cfg_inv_hs |
| in_vs | input | 1 | Vertical sync, polarity per cfg_inv_vs |
| cfg_sel0 | input | 2 | Source select for slot 0 (Y/R) |
| cfg_sel1 | input | 2 | Source select for slot 1 (Cb/G) |
| cfg_sel2 | input | 2 | Source select for slot 2 (Cr/B) |
| cfg_inv_de | input | 1 | Invert data-enable |
| cfg_inv_hs | input | 1 | Invert horizontal sync |
| cfg_inv_vs | input | 1 | Invert vertical sync |
| cfg_in_width | input | 3 | Input width code |
| cfg_out_fmt | input | 4 | Output format code |
| cfg_chroma_mode | input | 2 | Chroma decimation mode |
| out_c0 | output | CW | Output slot 0 |
| out_c1 | output | CW | Output slot 1 |
| out_c2 | output | CW | Output slot 2 |
| out_de | output | 1 | Data-enable, active high |
| out_hs | output | 1 | Horizontal sync, active high |
| out_vs | output | 1 | Vertical sync, active high |

## Verification
Three properties are checked on every clock. The strobes follow the inputs one clock later with the configured polarity. The chroma slots are zero on idle cycles and on even pixels of a 4:2:2 stream. An averaged chroma value always lies between the two samples it came from.

Other behaviour needs the bench's scenarios and its behavioural reference model:
- component routing for every select value, including 3;
- the width masks for each code;
- pair restart after an odd-length line;
- which pixel's chroma each mode keeps;
- truncation of the average.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned NSLOT = 3;

  // number of MSBs kept for a lane under a given width code
  function automatic int unsigned keep_bits(input logic [2:0] code, input int unsigned slot);
    case (code)
      3'd0:    keep_bits = 10;
      3'd1:    keep_bits = 8;
      3'd2:    keep_bits = 6;
      3'd3:    keep_bits = (slot == 1) ? 6 : 5;
      default: keep_bits = 32;
    endcase
  endfunction

  function automatic logic fmt_is_422(input logic [3:0] fmt);
    fmt_is_422 = (fmt == 4'd6) || (fmt == 4'd7) || (fmt == 4'd8);
  endfunction

  typedef enum logic [1:0] {
    CH_EVEN = 2'd0,
    CH_ODD  = 2'd1,
    CH_AVG  = 2'd2,
    CH_ALT  = 2'd3
  } chroma_mode_e;
endpackage

// File: rtl/pic_lane_mask.sv
module pic_lane_mask #(
  parameter int unsigned CW   = 10,
  parameter int unsigned SLOT = 0
) (
  input  logic [2:0]    width_code,
  input  logic [CW-1:0] d_in,
  output logic [CW-1:0] d_out
);
  import pic_pkg::*;
  int unsigned keep;
  logic [CW-1:0] mask;

  always_comb begin
    keep = keep_bits(width_code, SLOT);
    if (keep >= CW) mask = '1;
    else            mask = {CW{1'b1}} << (CW - keep);
    d_out = d_in & mask;
  end
endmodule

// File: rtl/pic_xbar.sv
module pic_xbar #(
  parameter int unsigned CW = 10
) (
  input  logic [2:0][CW-1:0] comps,
  input  logic [1:0]         sel,
  output logic [CW-1:0]      d_out
);
  always_comb begin
    case (sel)
      2'd1:    d_out = comps[1];
      2'd2:    d_out = comps[2];
      default: d_out = comps[0];
    endcase
  end
endmodule

// File: rtl/pic_chroma_dec.sv
module pic_chroma_dec #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          de_act,
  input  logic          is422,
  input  logic [1:0]    mode,
  input  logic [CW-1:0] cb_in,
  input  logic [CW-1:0] cr_in,
  output logic [CW-1:0] cb_o,
  output logic [CW-1:0] cr_o
);
  import pic_pkg::*;
  localparam int unsigned SW = CW + 1;

  logic          de_q, odd_flag_q, is_odd;
  logic [CW-1:0] cb_e_q, cr_e_q, cb_pick, cr_pick;
  logic [SW-1:0] cb_sum, cr_sum;

  assign is_odd = de_act & de_q & odd_flag_q;

  always_comb begin
    cb_sum = SW'(cb_e_q) + SW'(cb_in);
    cr_sum = SW'(cr_e_q) + SW'(cr_in);
    case (chroma_mode_e'(mode))
      CH_ODD: begin cb_pick = cb_in;             cr_pick = cr_in;             end
      CH_AVG: begin cb_pick = cb_sum[SW-1:1];    cr_pick = cr_sum[SW-1:1];    end
      default: begin cb_pick = cb_e_q;           cr_pick = cr_e_q;            end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      de_q       <= 1'b0;
      odd_flag_q <= 1'b0;
      cb_e_q     <= '0;
      cr_e_q     <= '0;
      cb_o       <= '0;
      cr_o       <= '0;
    end else begin
      de_q       <= de_act;
      odd_flag_q <= de_act ? ~(de_q & odd_flag_q) : 1'b0;
      if (de_act && !is_odd) begin
        cb_e_q <= cb_in;
        cr_e_q <= cr_in;
      end
      if (!is422) begin
        cb_o <= cb_in;
        cr_o <= cr_in;
      end else if (is_odd) begin
        cb_o <= cb_pick;
        cr_o <= cr_pick;
      end else begin
        cb_o <= '0;
        cr_o <= '0;
      end
    end
  end

  // assertion support: true once a clock edge out of reset has passed
  logic chk_armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;

  // R8: idle cycles and even pixels carry no chroma in 4:2:2 formats
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(is422 && !is_odd)) |-> (cb_o == '0 && cr_o == '0));

  // R9: an averaged value lies between the two samples it came from
  a_r9_avg_range: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_armed && $past(is422 && is_odd && mode == 2'd2)) |->
      ((cb_o >= $past(cb_e_q) || cb_o >= $past(cb_in)) &&
       (cb_o <= $past(cb_e_q) || cb_o <= $past(cb_in))));
endmodule

// File: rtl/pix_cond_top.sv
module pix_cond_top #(
  parameter int unsigned CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] in_c0,
  input  logic [CW-1:0] in_c1,
  input  logic [CW-1:0] in_c2,
  input  logic          in_de,
  input  logic          in_hs,
  input  logic          in_vs,
  input  logic [1:0]    cfg_sel0,
  input  logic [1:0]    cfg_sel1,
  input  logic [1:0]    cfg_sel2,
  input  logic          cfg_inv_de,
  input  logic          cfg_inv_hs,
  input  logic          cfg_inv_vs,
  input  logic [2:0]    cfg_in_width,
  input  logic [3:0]    cfg_out_fmt,
  input  logic [1:0]    cfg_chroma_mode,
  output logic [CW-1:0] out_c0,
  output logic [CW-1:0] out_c1,
  output logic [CW-1:0] out_c2,
  output logic          out_de,
  output logic          out_hs,
  output logic          out_vs
);
  import pic_pkg::*;

  logic [NSLOT-1:0][CW-1:0] raw, masked, routed;
  logic [NSLOT-1:0][1:0]    sels;
  logic de_act, hs_act, vs_act, is422;

  assign raw    = {in_c2, in_c1, in_c0};
  assign sels   = {cfg_sel2, cfg_sel1, cfg_sel0};
  assign de_act = in_de ^ cfg_inv_de;
  assign hs_act = in_hs ^ cfg_inv_hs;
  assign vs_act = in_vs ^ cfg_inv_vs;
  assign is422  = fmt_is_422(cfg_out_fmt);

  for (genvar s = 0; s < NSLOT; s++) begin : g_lane
    pic_lane_mask #(.CW(CW), .SLOT(s)) u_mask (
      .width_code (cfg_in_width),
      .d_in       (raw[s]),
      .d_out      (masked[s])
    );
    pic_xbar #(.CW(CW)) u_xbar (
      .comps (masked),
      .sel   (sels[s]),
      .d_out (routed[s])
    );
  end

  pic_chroma_dec #(.CW(CW)) u_chroma (
    .clk    (clk),
    .rst_n  (rst_n),
    .de_act (de_act),
    .is422  (is422),
    .mode   (cfg_chroma_mode),
    .cb_in  (routed[1]),
    .cr_in  (routed[2]),
    .cb_o   (out_c1),
    .cr_o   (out_c2)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_c0 <= '0;
      out_de <= 1'b0;
      out_hs <= 1'b0;
      out_vs <= 1'b0;
    end else begin
      out_c0 <= routed[0];
      out_de <= de_act;
      out_hs <= hs_act;
      out_vs <= vs_act;
    end
  end

  logic chk_armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) chk_armed <= 1'b0;
    else        chk_armed <= 1'b1;

  // R4, R5: strobes appear one clock later with configured polarity
  a_r5_de_align: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed |-> (out_de == $past(in_de ^ cfg_inv_de)));
  a_r4_sync_align: assert property (@(posedge clk) disable iff (!rst_n)
    chk_armed |-> (out_hs == $past(in_hs ^ cfg_inv_hs)) &&
                  (out_vs == $past(in_vs ^ cfg_inv_vs)));
endmodule

// File: tb/pix_cond_top_bench.sv
`timescale 1ns/1ps
module pix_cond_top_bench;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [CW-1:0] in_c0 = '0, in_c1 = '0, in_c2 = '0;
  logic in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
  logic [1:0] cfg_sel0 = 2'd0, cfg_sel1 = 2'd1, cfg_sel2 = 2'd2;
  logic cfg_inv_de = 1'b0, cfg_inv_hs = 1'b0, cfg_inv_vs = 1'b0;
  logic [2:0] cfg_in_width = 3'd0;
  logic [3:0] cfg_out_fmt = 4'd5;
  logic [1:0] cfg_chroma_mode = 2'd0;
  logic [CW-1:0] out_c0, out_c1, out_c2;
  logic out_de, out_hs, out_vs;

  always #2.5 clk = ~clk;

  pix_cond_top #(.CW(CW)) u_pix_cond_top (
    .clk(clk), .rst_n(rst_n),
    .in_c0(in_c0), .in_c1(in_c1), .in_c2(in_c2),
    .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs),
    .cfg_sel0(cfg_sel0), .cfg_sel1(cfg_sel1), .cfg_sel2(cfg_sel2),
    .cfg_inv_de(cfg_inv_de), .cfg_inv_hs(cfg_inv_hs), .cfg_inv_vs(cfg_inv_vs),
    .cfg_in_width(cfg_in_width), .cfg_out_fmt(cfg_out_fmt),
    .cfg_chroma_mode(cfg_chroma_mode),
    .out_c0(out_c0), .out_c1(out_c1), .out_c2(out_c2),
    .out_de(out_de), .out_hs(out_hs), .out_vs(out_vs)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit chk_en = 1'b0;

  // ---------------- behavioural reference model ----------------
  int e_c0, e_c1, e_c2, e_de, e_hs, e_vs;
  int m_prev_de, m_flag, m_cbe, m_cre;

  function automatic int mask_of(int v, int code, int slot);
    int keep;
    case (code)
      0: keep = 10;
      1: keep = 8;
      2: keep = 6;
      3: keep = (slot == 1) ? 6 : 5;
      default: keep = 10;
    endcase
    return (v >> (10 - keep)) << (10 - keep);
  endfunction

  function automatic int pick(int sel, int a, int b, int c);
    if (sel == 1) return b;
    if (sel == 2) return c;
    return a;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_c0 = 0; e_c1 = 0; e_c2 = 0; e_de = 0; e_hs = 0; e_vs = 0;
      m_prev_de = 0; m_flag = 0; m_cbe = 0; m_cre = 0;
    end else begin
      int a, b, c, y, cb, cr, de, odd, fmt422, md;
      a = mask_of(int'(in_c0), int'(cfg_in_width), 0);
      b = mask_of(int'(in_c1), int'(cfg_in_width), 1);
      c = mask_of(int'(in_c2), int'(cfg_in_width), 2);
      y  = pick(int'(cfg_sel0), a, b, c);
      cb = pick(int'(cfg_sel1), a, b, c);
      cr = pick(int'(cfg_sel2), a, b, c);
      de = int'(in_de ^ cfg_inv_de);
      fmt422 = (cfg_out_fmt == 6 || cfg_out_fmt == 7 || cfg_out_fmt == 8);
      md = int'(cfg_chroma_mode);
      odd = (de && m_prev_de && m_flag) ? 1 : 0;
      e_c0 = y;
      e_de = de;
      e_hs = int'(in_hs ^ cfg_inv_hs);
      e_vs = int'(in_vs ^ cfg_inv_vs);
      if (!fmt422) begin
        e_c1 = cb; e_c2 = cr;
      end else if (odd) begin
        if (md == 1)      begin e_c1 = cb; e_c2 = cr; end
        else if (md == 2) begin e_c1 = (m_cbe + cb) / 2; e_c2 = (m_cre + cr) / 2; end
        else              begin e_c1 = m_cbe; e_c2 = m_cre; end
      end else begin
        e_c1 = 0; e_c2 = 0;
      end
      if (de && !odd) begin m_cbe = cb; m_cre = cr; end
      m_flag = de ? (odd ? 0 : 1) : 0;
      m_prev_de = de;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (chk_en) begin
      checks++;
      if (int'(out_c0) != e_c0 || int'(out_c1) != e_c1 || int'(out_c2) != e_c2 ||
          int'(out_de) != e_de || int'(out_hs) != e_hs || int'(out_vs) != e_vs) begin
        failures++;
        $display("FAIL %s t=%0t actual c0=%0d c1=%0d c2=%0d de=%0b hs=%0b vs=%0b expected c0=%0d c1=%0d c2=%0d de=%0d hs=%0d vs=%0d",
                 cur_req, $time, out_c0, out_c1, out_c2, out_de, out_hs, out_vs,
                 e_c0, e_c1, e_c2, e_de, e_hs, e_vs);
      end
    end
  end

  // drive a stream of lines: line_len active pixels then 3 idle cycles
  task automatic run(input int ncyc, input int line_len);
    for (int i = 0; i < ncyc; i++) begin
      @(negedge clk);
      in_de = ((i % (line_len + 3)) < line_len) ^ cfg_inv_de;
      in_hs = 1'($urandom_range(0, 1));
      in_vs = 1'($urandom_range(0, 1));
      in_c0 = CW'($urandom_range(0, 1023));
      in_c1 = CW'($urandom_range(0, 1023));
      in_c2 = CW'($urandom_range(0, 1023));
    end
    @(negedge clk);
    in_de = cfg_inv_de;
    repeat (2) @(negedge clk);
  endtask

  task automatic setcfg(input int s0, input int s1, input int s2, input int w,
                        input int f, input int m, input int idv, input int ihs, input int ivs);
    @(negedge clk);
    cfg_sel0 = 2'(s0); cfg_sel1 = 2'(s1); cfg_sel2 = 2'(s2);
    cfg_in_width = 3'(w); cfg_out_fmt = 4'(f); cfg_chroma_mode = 2'(m);
    cfg_inv_de = 1'(idv); cfg_inv_hs = 1'(ihs); cfg_inv_vs = 1'(ivs);
    in_de = 1'(idv);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired in %s", cur_req);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    in_c0 = 10'h3ff; in_c1 = 10'h155; in_c2 = 10'h2aa; in_hs = 1'b1; in_vs = 1'b1; in_de = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset holds every output low
    checks++;
    if (out_c0 != 0 || out_c1 != 0 || out_c2 != 0 || out_de || out_hs || out_vs) begin
      failures++;
      $display("FAIL R1 actual c0=%0d c1=%0d c2=%0d de=%0b hs=%0b vs=%0b expected all 0",
               out_c0, out_c1, out_c2, out_de, out_hs, out_vs);
    end
    in_de = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk_en = 1'b1;

    cur_req = "R2 R5 default pass-through";    setcfg(0,1,2, 0,5,0, 0,0,0); run(40, 8);
    cur_req = "R2 permuted selects";           setcfg(2,0,1, 0,5,0, 0,0,0); run(40, 8);
    cur_req = "R3 select value 3";             setcfg(3,3,1, 0,5,0, 0,0,0); run(30, 8);
    cur_req = "R4 invert de";                  setcfg(0,1,2, 0,5,0, 1,0,0); run(30, 6);
    cur_req = "R4 invert hs vs";               setcfg(0,1,2, 0,5,0, 0,1,1); run(30, 6);
    cur_req = "R6 width 24-bit";               setcfg(0,1,2, 1,5,0, 0,0,0); run(30, 6);
    cur_req = "R6 width 18-bit";               setcfg(1,2,0, 2,4,0, 0,0,0); run(30, 6);
    cur_req = "R6 width 16-bit";               setcfg(0,1,2, 3,5,0, 0,0,0); run(30, 6);
    cur_req = "R7 non-422 code 4";             setcfg(0,1,2, 0,4,2, 0,0,0); run(30, 6);
    cur_req = "R8 R9 mode even fmt6";          setcfg(0,1,2, 0,6,0, 0,0,0); run(40, 8);
    cur_req = "R8 R9 mode odd fmt7";           setcfg(0,1,2, 0,7,1, 0,0,0); run(40, 8);
    cur_req = "R8 R9 mode avg fmt8";           setcfg(0,2,1, 0,8,2, 0,0,0); run(40, 8);
    cur_req = "R9 mode 3 as even";             setcfg(0,1,2, 0,6,3, 0,0,0); run(40, 8);
    cur_req = "R8 odd line restart";           setcfg(0,1,2, 0,8,2, 0,0,0); run(48, 5);
    cur_req = "R8 restart inverted de";        setcfg(0,1,2, 1,7,0, 1,1,0); run(48, 3);

    chk_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule